// File: doc/BRIEF.md
# Four-Channel Prescaled Interval Timer

This block holds four identical interval timers behind a flat register port. A single free-running prescale counter, clocked by the system clock, produces a base tick once every eight clocks and a family of slower ticks at that base rate divided by 1, 2, 4 and so on up to 128. Each channel picks one of these ticks through a 3-bit rate field. While enabled, it advances a 16-bit up-counter on every selected tick.

When a channel's counter reaches its compare value, the channel latches an interrupt request. On the following tick the counter restarts from zero, so the interval is compare+1 ticks. The request flag stays set until the matching clear input is pulsed. A disabled channel freezes its count, and software may then load a new starting value. This makes the block usable both as a periodic interval source and as a one-shot time-out detector that software re-arms.

Each channel is controlled by a two-state machine. OFF holds the count. RUN counts on ticks. A control write with the enable bit set takes OFF to RUN, and a control write with the enable bit clear takes RUN back to OFF. Every other write leaves the state unchanged.

Top module: `ptmr_top`

## Requirements
- R1: After reset every channel reads count 0, compare 0xFFFF and control 0, and every interrupt request is low.
- R2: The prescaler starts from zero at reset and ticks on clock k (k = 1, 2, ...) whenever k is a multiple of 8·2^n, where n is the channel's rate field (control bits 2:0).
- R3: In state RUN a channel's count rises by exactly one on each selected tick, unless the count equals the compare value.
- R4: A running channel whose count equals the compare value returns to 0 on its next tick, giving an interval of compare+1 ticks.
- R5: The channel's interrupt request goes high on the clock edge at which its count takes the compare value. With compare 0 it is set on every tick.
- R6: An interrupt request stays high until its clear input is high at a clock edge. A clear in the same cycle as a new match leaves it high.
- R7: In state OFF the count holds. A count write (select 0) loads the written value only in state OFF and is ignored in state RUN.
- R8: The four channels run independently, each with its own rate, compare value, enable and interrupt.
- R9: Register selects are 0 = count, 1 = compare, 2 = control (bit 3 enable, bits 2:0 rate, upper bits read 0), and 3 = unused (reads 0, writes ignored). Compare and control writes take effect in any state.
- R10: A count loaded above the compare value counts up to 0xFFFF, wraps to 0, and then matches normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by a write |
| wr_sel | input | 2 | Register select for a write |
| wr_data | input | 16 | Write data |
| rd_ch | input | 2 | Channel addressed by a read |
| rd_sel | input | 2 | Register select for a read |
| rd_data | output | 16 | Combinational read data |
| irq_clr | input | 4 | Per-channel interrupt clear |
| irq | output | 4 | Per-channel interrupt request |

## Verification
A wrong prescaler phase or a wrong rate selection shows up at the count readback within one tick of the chosen rate, which is at most 1024 clocks. From then on every later interrupt edge is shifted. A wrong count, a missed wrap or a wrong state is visible on the read port in the very next cycle after the faulty edge. The bench sweeps all sixteen channel/register read slots continuously, so any such error is seen within sixteen cycles. A lost or spurious interrupt flag is visible on the irq output in the cycle after the edge that corrupted it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_e;

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int BASE_LOG2 = 3,
    parameter int RATE_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [(1<<RATE_W)-1:0]   tick
);
    localparam int NRATE = 1 << RATE_W;
    localparam int PW    = BASE_LOG2 + NRATE - 1;
    localparam int BASE  = 1 << BASE_LOG2;

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + PW'(1);
    end

    for (genvar n = 0; n < NRATE; n++) begin : g_tick
        assign tick[n] = &pre_q[BASE_LOG2+n-1:0];
    end

    // checker: spacing between successive base ticks
    logic [PW-1:0] gap_q;
    logic          seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick[0]) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + PW'(1);
        end
    end

    AST_BASE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick[0] && seen_q) |-> (gap_q == PW'(BASE - 1))); // R2

endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
#(
    parameter int CW     = 16,
    parameter int RATE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [(1<<RATE_W)-1:0]  tick_vec,
    input  logic                    wr_cnt,
    input  logic                    wr_cmp,
    input  logic                    wr_ctrl,
    input  logic [CW-1:0]           wdata,
    input  logic                    irq_clr,
    output logic [CW-1:0]           cnt_q,
    output logic [CW-1:0]           cmp_q,
    output logic                    run,
    output logic [RATE_W-1:0]       rate_q,
    output logic                    irq
);
    ch_state_e   st_q, st_nxt;
    logic        tick_sel;
    logic [CW-1:0] cnt_nxt;
    logic        hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_nxt;
    end

    // transitions: ENABLE (OFF->RUN), DISABLE (RUN->OFF)
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            CH_OFF: if (wr_ctrl &&  wdata[RATE_W]) st_nxt = CH_RUN;
            CH_RUN: if (wr_ctrl && !wdata[RATE_W]) st_nxt = CH_OFF;
        endcase
    end

    // per-state count behaviour
    always_comb begin
        tick_sel = tick_vec[rate_q];
        cnt_nxt  = cnt_q;
        hit      = 1'b0;
        unique case (st_q)
            CH_OFF: begin
                if (wr_cnt) cnt_nxt = wdata;
            end
            CH_RUN: begin
                if (tick_sel) begin
                    cnt_nxt = (cnt_q == cmp_q) ? '0 : cnt_q + CW'(1);
                    hit     = (cnt_nxt == cmp_q);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '1;
            rate_q <= '0;
            irq    <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (wr_cmp)  cmp_q  <= wdata;
            if (wr_ctrl) rate_q <= wdata[RATE_W-1:0];
            irq <= hit | (irq & ~irq_clr);
        end
    end

    assign run = (st_q == CH_RUN);

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OFF && !wr_cnt) |=> (cnt_q == $past(cnt_q))); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && tick_sel && cnt_q != cmp_q) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN && tick_sel && cnt_q == cmp_q) |=> (cnt_q == '0)); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R6
    AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !$past(wr_cmp)) |-> (cnt_q == cmp_q)); // R5

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CW        = 16,
    parameter int RATE_W    = 3,
    parameter int BASE_LOG2 = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NCH)-1:0]   wr_ch,
    input  logic [1:0]               wr_sel,
    input  logic [CW-1:0]            wr_data,
    input  logic [$clog2(NCH)-1:0]   rd_ch,
    input  logic [1:0]               rd_sel,
    output logic [CW-1:0]            rd_data,
    input  logic [NCH-1:0]           irq_clr,
    output logic [NCH-1:0]           irq
);
    localparam int NRATE = 1 << RATE_W;
    localparam int PADW  = CW - RATE_W - 1;

    logic [NRATE-1:0]  tick;
    logic [CW-1:0]     cnt_a  [NCH];
    logic [CW-1:0]     cmp_a  [NCH];
    logic [RATE_W-1:0] rate_a [NCH];
    logic [NCH-1:0]    run_a;

    ptmr_prescale #(.BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel_me;
        assign sel_me = wr_en && (wr_ch == c);

        ptmr_channel #(.CW(CW), .RATE_W(RATE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_vec (tick),
            .wr_cnt   (sel_me && (reg_sel_e'(wr_sel) == SEL_COUNT)),
            .wr_cmp   (sel_me && (reg_sel_e'(wr_sel) == SEL_CMP)),
            .wr_ctrl  (sel_me && (reg_sel_e'(wr_sel) == SEL_CTRL)),
            .wdata    (wr_data),
            .irq_clr  (irq_clr[c]),
            .cnt_q    (cnt_a[c]),
            .cmp_q    (cmp_a[c]),
            .run      (run_a[c]),
            .rate_q   (rate_a[c]),
            .irq      (irq[c])
        );
    end

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_COUNT: rd_data = cnt_a[rd_ch];
            SEL_CMP:   rd_data = cmp_a[rd_ch];
            SEL_CTRL:  rd_data = {{PADW{1'b0}}, run_a[rd_ch], rate_a[rd_ch]};
            SEL_NONE:  rd_data = '0;
        endcase
    end

    AST_IRQ_CLEAN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0)); // R1

endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_ch = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [3:0]  irq_clr = '0;
    logic [3:0]  irq;

    always #(PERIOD/2) clk = ~clk;

    ptmr_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_clr(irq_clr), .irq(irq)
    );

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference
    int m_cnt [4];
    int m_cmp [4];
    int m_en  [4];
    int m_rate[4];
    int m_irq [4];
    longint pc;

    always @(posedge clk) begin
        if (!rst_n) begin
            pc = 0;
            for (int c = 0; c < 4; c++) begin
                m_cnt[c] = 0; m_cmp[c] = 16'hFFFF; m_en[c] = 0; m_rate[c] = 0; m_irq[c] = 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                longint per;
                int ncnt, ncmp, nen, nrate;
                bit tk, set;
                per   = 64'd8 << m_rate[c];
                tk    = ((pc % per) == per - 1);
                ncnt  = m_cnt[c];
                ncmp  = m_cmp[c];
                nen   = m_en[c];
                nrate = m_rate[c];
                set   = 1'b0;
                if (m_en[c] != 0 && tk) begin
                    ncnt = (m_cnt[c] == m_cmp[c]) ? 0 : ((m_cnt[c] + 1) % 65536);
                    set  = (ncnt == m_cmp[c]);
                end
                if (wr_en && wr_ch == c) begin
                    if (wr_sel == 0 && m_en[c] == 0) ncnt = wr_data;
                    if (wr_sel == 1) ncmp = wr_data;
                    if (wr_sel == 2) begin nen = wr_data[3]; nrate = wr_data[2:0]; end
                end
                m_irq[c]  = (set || (m_irq[c] != 0 && !irq_clr[c])) ? 1 : 0;
                m_cnt[c]  = ncnt;
                m_cmp[c]  = ncmp;
                m_en[c]   = nen;
                m_rate[c] = nrate;
            end
            pc = pc + 1;
        end
    end

    function automatic int model_read(int c, int s);
        case (s)
            0: return m_cnt[c];
            1: return m_cmp[c];
            2: return (m_en[c] << 3) | m_rate[c];
            default: return 0;
        endcase
    endfunction

    // compare every clock, then rotate the read slot
    int rd_idx = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_rd, exp_irq;
            exp_rd  = model_read(int'(rd_ch), int'(rd_sel));
            exp_irq = (m_irq[3] << 3) | (m_irq[2] << 2) | (m_irq[1] << 1) | m_irq[0];
            tests++;
            if (int'(rd_data) != exp_rd) begin
                fails++;
                $display("FAIL %s rd ch%0d sel%0d: actual %h expected %h", cur_req,
                         rd_ch, rd_sel, rd_data, exp_rd[15:0]);
            end
            tests++;
            if (int'(irq) != exp_irq) begin
                fails++;
                $display("FAIL %s irq: actual %b expected %b", cur_req, irq, exp_irq[3:0]);
            end
        end
        rd_idx = (rd_idx + 1) % 16;
        rd_ch  = 2'(rd_idx / 4);
        rd_sel = 2'(rd_idx % 4);
    end

    task automatic wr(input int c, input int s, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(c); wr_sel = 2'(s); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        cur_req = "R1";                       // reset values
        idle(20);
        cur_req = "R3";                       // R3/R4/R5: ch0 rate 0, compare 3
        wr(0, 1, 3);
        wr(0, 2, 8);
        idle(200);
        cur_req = "R8";                       // R2/R8: mixed rates on all channels
        wr(1, 1, 5);   wr(1, 2, 8 | 2);
        wr(2, 1, 1);   wr(2, 2, 8 | 7);
        wr(3, 1, 0);   wr(3, 2, 8 | 1);
        idle(4500);
        cur_req = "R6";                       // clear held across matches
        irq_clr = 4'b1111;
        idle(60);
        irq_clr = 4'b0101;
        idle(40);
        irq_clr = 4'b0000;
        idle(100);
        cur_req = "R7";                       // disable, load, ignored write in RUN
        wr(0, 2, 0);
        idle(30);
        wr(0, 0, 16'hFFF0);
        idle(20);
        cur_req = "R10";                      // above-compare start wraps through 0xFFFF
        wr(0, 2, 8);
        wr(0, 0, 16'h0123);
        idle(300);
        cur_req = "R9";                       // unused select, compare rewrite while running
        wr(1, 3, 16'hBEEF);
        wr(1, 1, 2);
        wr(2, 2, 16'hFFF0);
        idle(200);
        cur_req = "R4";                       // compare 0 on base rate
        wr(3, 2, 8);
        idle(100);
        cur_req = "R2";
        wr(2, 2, 8 | 4);
        idle(600);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule